// File: doc/BRIEF.md
# Synchronous burst read sequencer

This block drives the read path of a memory that offers two ways to read. After power-on reset it works in asynchronous mode. There the array address simply follows the external address while chip enable is low, and the burst clock and address strobe have no effect. Setting the enable bit in the configuration word switches the block to clocked burst mode.

In burst mode, a one-edge address strobe loads a start address. The block then waits a programmable number of active burst-clock edges. After that it steps the array address linearly on every active edge and pulses a data-valid flag for each word. A burst may be continuous, or it may be a fixed 4, 8 or 16 words that wrap within an aligned window. Either the rising or the falling edge of the burst clock can be chosen as the active edge.

The burst clock is oversampled by the block clock. A reset command stops a burst in flight but does not leave burst mode. Only power-on reset, or clearing the enable bit, does that.

Top module: `burst_read_seq`

## Requirements
- R1: On power-on reset (`rst` high at a clock edge) `burst_mode`, `dvalid` and `arr_addr` all go to zero, so the block starts in asynchronous mode.
- R2: While `burst_mode` is 0, `arr_addr` takes the value of `ext_addr` one clock after any cycle in which `ce_n` is low, and holds its value while `ce_n` is high. `dvalid` stays low, and `bclk` and `adv_n` have no effect.
- R3: A cycle with `cfg_wr` high stores `cfg_data` as follows: bit 0 is the burst enable, bits 3:1 the latency code, bit 4 the edge select, and bits 6:5 the burst length. `burst_mode` shows bit 0 from the next clock on.
- R4: In burst mode, an active burst-clock edge with `adv_n` and `ce_n` both low loads `ext_addr` as the burst start address. Later values of `ext_addr` do not affect that burst.
- R5: The first data word is flagged on the (code+2)-th active edge after the load edge, so the latency is 2 to 9 edges. `dvalid` stays low on all earlier edges.
- R6: Edge select 0 makes a 0-to-1 change of `bclk` the active edge. Edge select 1 makes a 1-to-0 change the active edge. The opposite change does nothing.
- R7: Each data word sets `dvalid` high for exactly the one clock that follows its active edge. The first word is at the start address, and each later active edge advances the address by one.
- R8: Length code 00 gives a continuous burst that counts modulo 2^AW. Codes 01, 10 and 11 give 4, 8 and 16 words. In these fixed bursts only the low log2(length) address bits count, wrapping within the aligned window, and after the last word no further `dvalid` appears.
- R9: `ce_n` high aborts a burst: `dvalid` is low on the next clock, and the burst does not resume when `ce_n` returns low.
- R10: A `cmd_reset` pulse aborts the running burst, with `dvalid` low on the next clock. `burst_mode` is unchanged, and a new strobe starts a fresh burst.
- R11: Clearing the enable bit returns the block to asynchronous mode, with R2 behaviour from then on.
- R12: While `oe_n` is high, a due word gives no `dvalid` pulse, but the address still advances as if the word had been taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, oversamples the burst clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | 7 | Configuration word (enable, latency, edge, length) |
| cmd_reset | input | 1 | Reset command pulse |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| bclk | input | 1 | Burst clock |
| ext_addr | input | AW | External address |
| arr_addr | output | AW | Internal array address |
| dvalid | output | 1 | Data-valid pulse, one per burst word |
| burst_mode | output | 1 | 1 when clocked burst mode is active |

## Verification
The bench sweeps every latency code, both edge selects and all four length codes. It uses one start address mid-range and one just below the top of the address space.

- **Off-by-one latency.** A design that counts the load edge, or one that misses one, shows `dvalid` an edge early or late.
- **Wrong wrap.** A design with the wrong wrap mask carries out of the aligned window, or fails to wrap past all-ones.
- **Edge select ignored.** Such a design flags words on the wrong half of the burst clock.
- **Aborts and the reset command.** Targeted sequences cover chip-enable abort, the reset command, clearing the enable bit and output-enable masking. They would catch a design that resumes an aborted burst, drops burst mode on the reset command, or stalls the address while the output is disabled.

// File: rtl/brs_pkg.sv
package brs_pkg;

    typedef struct packed {
        logic [1:0] blen;      // 00 continuous, 01 x4, 10 x8, 11 x16
        logic       edge_fall; // 1: falling edge of bclk is active
        logic [2:0] lat;       // initial latency code, edges = code + 2
        logic       en;        // synchronous burst enable
    } cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_STREAM = 2'd2
    } state_t;

    function automatic logic [3:0] lat_edges(input logic [2:0] code);
        return {1'b0, code} + 4'd2;
    endfunction

    // index of the last word in a fixed burst (also the wrap mask)
    function automatic logic [3:0] last_index(input logic [1:0] blen);
        case (blen)
            2'b01:   return 4'd3;
            2'b10:   return 4'd7;
            2'b11:   return 4'd15;
            default: return 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/brs_cfg_reg.sv
module brs_cfg_reg
    import brs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [6:0] din,
    output cfg_t       cfg
);
    always_ff @(posedge clk) begin
        if (rst)     cfg <= '0;
        else if (wr) cfg <= cfg_t'(din);
    end
endmodule

// File: rtl/brs_edge_det.sv
module brs_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic bclk,
    input  logic fall_sel,
    output logic tick
);
    logic bclk_q;

    always_ff @(posedge clk) begin
        if (rst) bclk_q <= 1'b0;
        else     bclk_q <= bclk;
    end

    always_comb begin
        if (fall_sel) tick = bclk_q & ~bclk;
        else          tick = ~bclk_q & bclk;
    end
endmodule

// File: rtl/brs_burst_ctr.sv
module brs_burst_ctr
    import brs_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [2:0]    lat,
    input  logic [1:0]    blen,
    input  logic          tick,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          adv_n,
    input  logic          cmd_reset,
    input  logic [AW-1:0] ext_addr,
    output logic [AW-1:0] addr,
    output logic          dvalid
);
    localparam int CW = 4;

    state_t        st, st_n;
    logic [CW-1:0] cnt, cnt_n;
    logic [CW-1:0] wc, wc_n;
    logic [AW-1:0] addr_n, mask, addr_step;
    logic          dv_n;

    always_comb begin
        if (blen == 2'b00) mask = '1;
        else               mask = AW'(last_index(blen));
        addr_step = (addr & ~mask) | ((addr + 1'b1) & mask);
    end

    always_comb begin
        st_n   = st;
        cnt_n  = cnt;
        wc_n   = wc;
        addr_n = addr;
        dv_n   = 1'b0;
        if (!en) begin
            st_n = ST_IDLE;
            if (!ce_n) addr_n = ext_addr;
        end else if (ce_n || cmd_reset) begin
            st_n = ST_IDLE;
        end else if (tick) begin
            if (!adv_n) begin
                st_n   = ST_WAIT;
                cnt_n  = lat_edges(lat);
                wc_n   = '0;
                addr_n = ext_addr;
            end else begin
                case (st)
                    ST_WAIT: begin
                        if (cnt == CW'(1)) begin
                            st_n = ST_STREAM;
                            dv_n = ~oe_n;
                        end else begin
                            cnt_n = cnt - 1'b1;
                        end
                    end
                    ST_STREAM: begin
                        if (blen != 2'b00 && wc == last_index(blen)) begin
                            st_n = ST_IDLE;
                        end else begin
                            addr_n = addr_step;
                            wc_n   = wc + 1'b1;
                            dv_n   = ~oe_n;
                        end
                    end
                    default: st_n = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            wc     <= '0;
            addr   <= '0;
            dvalid <= 1'b0;
        end else begin
            st     <= st_n;
            cnt    <= cnt_n;
            wc     <= wc_n;
            addr   <= addr_n;
            dvalid <= dv_n;
        end
    end
endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
    import brs_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_wr,
    input  logic [6:0]    cfg_data,
    input  logic          cmd_reset,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          adv_n,
    input  logic          bclk,
    input  logic [AW-1:0] ext_addr,
    output logic [AW-1:0] arr_addr,
    output logic          dvalid,
    output logic          burst_mode
);
    cfg_t cfg;
    logic tick;

    brs_cfg_reg u_cfg (
        .clk (clk),
        .rst (rst),
        .wr  (cfg_wr),
        .din (cfg_data),
        .cfg (cfg)
    );

    brs_edge_det u_edge (
        .clk      (clk),
        .rst      (rst),
        .bclk     (bclk),
        .fall_sel (cfg.edge_fall),
        .tick     (tick)
    );

    brs_burst_ctr #(.AW(AW)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .en        (cfg.en),
        .lat       (cfg.lat),
        .blen      (cfg.blen),
        .tick      (tick),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .adv_n     (adv_n),
        .cmd_reset (cmd_reset),
        .ext_addr  (ext_addr),
        .addr      (arr_addr),
        .dvalid    (dvalid)
    );

    assign burst_mode = cfg.en;
endmodule

// File: rtl/brs_checker.sv
module brs_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_wr,
    input logic          cmd_reset,
    input logic          ce_n,
    input logic          oe_n,
    input logic          tick,
    input logic [AW-1:0] ext_addr,
    input logic [AW-1:0] arr_addr,
    input logic          dvalid,
    input logic          burst_mode
);
    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!dvalid && !burst_mode)); // R1

    AST_ASYNC_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        (!burst_mode && !$past(burst_mode)) |-> !dvalid); // R2

    AST_ASYNC_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (!burst_mode && !ce_n) |=> (arr_addr == $past(ext_addr))); // R2

    AST_VALID_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        dvalid |-> $past(tick)); // R7

    AST_CE_ABORT: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> !dvalid); // R9

    AST_CMD_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
        (cmd_reset && !cfg_wr) |=> (burst_mode == $past(burst_mode))); // R10

    AST_CMD_ABORT: assert property (@(posedge clk) disable iff (rst)
        cmd_reset |=> !dvalid); // R10

    AST_OE_GATE: assert property (@(posedge clk) disable iff (rst)
        oe_n |=> !dvalid); // R12
endmodule

bind burst_read_seq brs_checker #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr     (cfg_wr),
    .cmd_reset  (cmd_reset),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .tick       (tick),
    .ext_addr   (ext_addr),
    .arr_addr   (arr_addr),
    .dvalid     (dvalid),
    .burst_mode (burst_mode)
);

// File: tb/sim_burst_read_seq.sv
`timescale 1ns/1ps
module sim_burst_read_seq;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr = 1'b0;
    logic [6:0]    cfg_data = '0;
    logic          cmd_reset = 1'b0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b0;
    logic          adv_n = 1'b1;
    logic          bclk = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic [AW-1:0] arr_addr;
    logic          dvalid;
    logic          burst_mode;

    int n_cmp = 0;
    int n_bad = 0;
    logic cur_fall = 1'b0;

    always #2 clk = ~clk;

    burst_read_seq #(.AW(AW)) u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .cmd_reset(cmd_reset), .ce_n(ce_n), .oe_n(oe_n), .adv_n(adv_n),
        .bclk(bclk), .ext_addr(ext_addr), .arr_addr(arr_addr),
        .dvalid(dvalid), .burst_mode(burst_mode)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // one burst-clock period: inactive transition, then active transition
    task automatic tick();
        bclk = cur_fall;
        @(negedge clk);
        bclk = ~cur_fall;
        @(negedge clk);
    endtask

    task automatic wcfg(input bit en, input int lat, input bit fall, input int blen);
        cfg_data = {2'(blen), fall, 3'(lat), en};
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        cur_fall = fall;
        bclk = fall;
        @(negedge clk);
    endtask

    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] a, input int blen, input int w);
        logic [AW-1:0] m;
        m = (blen == 0) ? '1 : AW'((4 << (blen - 1)) - 1);
        return (a & ~m) | ((a + AW'(w)) & m);
    endfunction

    task automatic load(input logic [AW-1:0] a);
        ext_addr = a;
        adv_n = 1'b0;
        ce_n = 1'b0;
        tick();
        adv_n = 1'b1;
        ext_addr = ~a;
    endtask

    task automatic run_burst(input int lat, input bit fall, input int blen, input logic [AW-1:0] a);
        int nw;
        wcfg(1'b1, lat, fall, blen);
        load(a);                                          // R4
        for (int k = 1; k < lat + 2; k++) begin
            tick();
            chk(dvalid == 1'b0, "R5", dvalid, 0);
        end
        nw = (blen == 0) ? 20 : (4 << (blen - 1));
        for (int w = 0; w < nw; w++) begin
            tick();
            chk(dvalid == 1'b1, fall ? "R6" : "R7", dvalid, 1);
            chk(arr_addr == exp_addr(a, blen, w), blen == 0 ? "R7" : "R8",
                arr_addr, exp_addr(a, blen, w));
            @(negedge clk);
            chk(dvalid == 1'b0, "R7", dvalid, 0);        // single-clock pulse
            bclk = ~cur_fall;
        end
        if (blen != 0) begin
            tick();
            chk(dvalid == 1'b0, "R8", dvalid, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(burst_mode == 1'b0, "R1", burst_mode, 0);
        chk(dvalid == 1'b0, "R1", dvalid, 0);
        chk(arr_addr == '0, "R1", arr_addr, 0);

        // R2 asynchronous follow / hold / strobe ignored
        ce_n = 1'b0;
        for (int i = 1; i < 6; i++) begin
            ext_addr = AW'(i * 16'h1357);
            @(negedge clk);
            chk(arr_addr == AW'(i * 16'h1357), "R2", arr_addr, i * 16'h1357);
        end
        adv_n = 1'b0;
        for (int i = 0; i < 12; i++) begin
            tick();
            chk(dvalid == 1'b0, "R2", dvalid, 0);
        end
        adv_n = 1'b1;
        ext_addr = 16'hA5A5;
        @(negedge clk);
        ce_n = 1'b1;
        ext_addr = 16'h0F0F;
        @(negedge clk);
        @(negedge clk);
        chk(arr_addr == 16'hA5A5, "R2", arr_addr, 16'hA5A5);

        // R3 enable bit visible on burst_mode
        wcfg(1'b1, 0, 1'b0, 0);
        chk(burst_mode == 1'b1, "R3", burst_mode, 1);

        // sweep: latency x edge x length x start address
        for (int f = 0; f < 2; f++)
            for (int l = 0; l < 8; l++)
                for (int b = 0; b < 4; b++) begin
                    run_burst(l, f[0], b, 16'h1235);
                    run_burst(l, f[0], b, 16'hFFFD);
                end

        // R9 chip-enable abort
        wcfg(1'b1, 0, 1'b0, 0);
        load(16'h0200);
        repeat (3) tick();
        chk(dvalid == 1'b1, "R9", dvalid, 1);
        ce_n = 1'b1;
        bclk = 1'b0;
        @(negedge clk);
        chk(dvalid == 1'b0, "R9", dvalid, 0);
        ce_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            tick();
            chk(dvalid == 1'b0, "R9", dvalid, 0);
        end

        // R10 reset command aborts but keeps burst mode
        load(16'h0300);
        repeat (3) tick();
        chk(dvalid == 1'b1, "R10", dvalid, 1);
        cmd_reset = 1'b1;
        bclk = 1'b0;
        @(negedge clk);
        cmd_reset = 1'b0;
        chk(dvalid == 1'b0, "R10", dvalid, 0);
        chk(burst_mode == 1'b1, "R10", burst_mode, 1);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk(dvalid == 1'b0, "R10", dvalid, 0);
        end
        load(16'h0400);
        tick();
        tick();
        chk(dvalid == 1'b1 && arr_addr == 16'h0400, "R10", arr_addr, 16'h0400);

        // R12 output disable masks a word but the address keeps stepping
        oe_n = 1'b1;
        tick();
        chk(dvalid == 1'b0, "R12", dvalid, 0);
        oe_n = 1'b0;
        tick();
        chk(dvalid == 1'b1 && arr_addr == 16'h0402, "R12", arr_addr, 16'h0402);

        // R11 clearing enable returns to asynchronous mode
        wcfg(1'b0, 0, 1'b0, 0);
        chk(burst_mode == 1'b0, "R11", burst_mode, 0);
        ext_addr = 16'h7777;
        @(negedge clk);
        chk(arr_addr == 16'h7777, "R11", arr_addr, 16'h7777);
        adv_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            tick();
            chk(dvalid == 1'b0, "R11", dvalid, 0);
        end
        adv_n = 1'b1;

        // R1 power-on reset leaves burst mode
        wcfg(1'b1, 0, 1'b0, 0);
        load(16'h0500);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(burst_mode == 1'b0, "R1", burst_mode, 0);
        chk(dvalid == 1'b0, "R1", dvalid, 0);

        finish_run();
    end
endmodule